// File: doc/BRIEF.md
# Multi-Cycle Processor Sequencing Controller

This block is the control unit of a processor whose datapath shares one ALU and one memory port across several clock cycles per instruction. It looks at the 6-bit major opcode held in the instruction register and walks a state machine. Each state drives the write enables, memory strobes, multiplexer selects and ALU operation class that the datapath needs for that step. Every instruction starts with the same two states. In the first, the instruction is loaded and the program counter is advanced by four. In the second, both source registers are read and a branch target is computed, whatever the instruction turns out to be. After that the path splits by instruction class, and the machine returns to the first state when the instruction completes.

Register-to-register operations take four cycles, as do word stores. Word loads take five cycles and equal-compare branches take three. An opcode the block does not recognise ends after the second state and has no effect on architectural state. The datapath supplies an equality flag from its ALU. The block combines this flag with its conditional program-counter write, so a branch loads its target only when the compared registers match.

Top module: `mcc_ctrl`

## Requirements
- R1: While `rst` is high at a rising edge, the next state is the fetch state, whatever state the machine was in before. Reset is synchronous and active high.
- R2: The fetch state asserts exactly `pc_we`, `ir_we` and `mem_rd`, with `addr_sel`=0 (PC), `alu_a_sel`=0 (PC), `alu_b_sel`=1 (constant 4), `alu_op`=0 (add) and `pc_src`=0 (ALU result). All other outputs are 0.
- R3: The state after fetch always asserts `ab_we` and `aluout_we` together, with `alu_a_sel`=0 (PC), `alu_b_sel`=3 (immediate shifted left by 2) and `alu_op`=0. It asserts no write enable other than those two.
- R4: Opcode 0x04 (branch-equal) runs fetch, decode, compare. The compare state has `alu_a_sel`=1 (A), `alu_b_sel`=0 (B), `alu_op`=1 (subtract) and `pc_src`=1 (ALUOut). In that state `pc_we` equals `alu_zero`.
- R5: Opcode 0x00 (register type) runs fetch, decode, execute, write-back. Execute has `alu_a_sel`=1, `alu_b_sel`=0, `alu_op`=2 (function field) and `aluout_we`=1. Write-back has `rf_we`=1, `rf_dst_sel`=1 (rd) and `rf_data_sel`=0 (ALUOut).
- R6: Opcode 0x2B (store word) runs fetch, decode, address, store. Address has `alu_a_sel`=1, `alu_b_sel`=2 (sign-extended immediate), `alu_op`=0 and `aluout_we`=1. Store has `mem_wr`=1 and `addr_sel`=1 (ALUOut).
- R7: Opcode 0x23 (load word) runs fetch, decode, address, read, write-back. Read has `mem_rd`=1, `addr_sel`=1 and `mdr_we`=1. Write-back has `rf_we`=1, `rf_dst_sel`=0 (rt) and `rf_data_sel`=1 (MDR).
- R8: Any other opcode returns to fetch directly after decode, so it asserts no `mem_wr`, `rf_we`, `mdr_we` or `pc_we` outside fetch.
- R9: `mem_rd` and `mem_wr` are never high in the same cycle, and `mem_wr` and `rf_we` are never high in the same cycle.
- R10: After the last state of any instruction, the next state is fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 6 | Major opcode from the instruction register |
| alu_zero | input | 1 | ALU result-is-zero flag from the datapath |
| pc_we | output | 1 | Program counter write enable |
| ir_we | output | 1 | Instruction register write enable |
| ab_we | output | 1 | Operand registers A and B write enable |
| aluout_we | output | 1 | ALU output register write enable |
| mdr_we | output | 1 | Memory data register write enable |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| rf_we | output | 1 | Register file write enable |
| addr_sel | output | 1 | Memory address: 0 PC, 1 ALUOut |
| alu_a_sel | output | 1 | ALU A input: 0 PC, 1 register A |
| alu_b_sel | output | 2 | ALU B input: 0 B, 1 constant 4, 2 immediate, 3 immediate shifted by 2 |
| alu_op | output | 2 | ALU class: 0 add, 1 subtract, 2 function field |
| pc_src | output | 1 | PC source: 0 ALU result, 1 ALUOut |
| rf_dst_sel | output | 1 | Register write address: 0 rt, 1 rd |
| rf_data_sel | output | 1 | Register write data: 0 ALUOut, 1 MDR |

## Verification
Two pairs of work share a cycle. In decode, the operand registers load alongside the speculative branch target. In fetch, the instruction register loads alongside the program-counter increment. Both pairs are provoked by every instruction in the vector table and judged by comparing the full control word in that cycle. The branch compare state, where the conditional PC load depends on the same-cycle `alu_zero` flag, is run with the flag both set and clear. Register and load instructions are also run with the flag set, to show that it is ignored outside the compare state.

// File: rtl/mcc_pkg.sv
package mcc_pkg;

    localparam int OPC_W = 6;

    typedef enum logic [3:0] {
        ST_FETCH, ST_DECODE, ST_ADDR, ST_EXEC, ST_BRANCH,
        ST_RD, ST_WR, ST_RWB, ST_LWB
    } state_e;

    typedef enum logic [2:0] {
        CL_RTYPE, CL_LOAD, CL_STORE, CL_BRANCH, CL_OTHER
    } iclass_e;

    typedef enum logic [1:0] {
        BSRC_REG  = 2'd0,
        BSRC_FOUR = 2'd1,
        BSRC_IMM  = 2'd2,
        BSRC_BOFF = 2'd3
    } bsrc_e;

    typedef enum logic [1:0] {
        AOP_ADD   = 2'd0,
        AOP_SUB   = 2'd1,
        AOP_FUNCT = 2'd2
    } aop_e;

    typedef struct packed {
        logic  pc_write;
        logic  pc_cond;
        logic  ir_we;
        logic  ab_we;
        logic  aluout_we;
        logic  mdr_we;
        logic  mem_rd;
        logic  mem_wr;
        logic  rf_we;
        logic  addr_sel;
        logic  alu_a_sel;
        bsrc_e alu_b_sel;
        aop_e  alu_op;
        logic  pc_src;
        logic  rf_dst_sel;
        logic  rf_data_sel;
    } ctrl_t;

    function automatic ctrl_t ctrl_idle();
        ctrl_t c;
        c = '0;
        c.alu_b_sel = BSRC_REG;
        c.alu_op    = AOP_ADD;
        return c;
    endfunction

endpackage

// File: rtl/mcc_decode.sv
module mcc_decode
    import mcc_pkg::*;
#(
    parameter int               W       = OPC_W,
    parameter logic [W-1:0]     OP_RT   = 'h00,
    parameter logic [W-1:0]     OP_LW   = 'h23,
    parameter logic [W-1:0]     OP_SW   = 'h2B,
    parameter logic [W-1:0]     OP_BEQ  = 'h04
) (
    input  logic [W-1:0] opcode,
    output iclass_e      cls
);
    always_comb begin
        if (opcode == OP_RT)       cls = CL_RTYPE;
        else if (opcode == OP_LW)  cls = CL_LOAD;
        else if (opcode == OP_SW)  cls = CL_STORE;
        else if (opcode == OP_BEQ) cls = CL_BRANCH;
        else                       cls = CL_OTHER;
    end
endmodule

// File: rtl/mcc_seq.sv
module mcc_seq
    import mcc_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  iclass_e cls,
    output state_e  state
);
    state_e nxt;

    always_comb begin
        nxt = ST_FETCH;
        unique case (state)
            ST_FETCH:  nxt = ST_DECODE;
            ST_DECODE: begin
                unique case (cls)
                    CL_RTYPE:          nxt = ST_EXEC;
                    CL_LOAD, CL_STORE: nxt = ST_ADDR;
                    CL_BRANCH:         nxt = ST_BRANCH;
                    default:           nxt = ST_FETCH;
                endcase
            end
            ST_ADDR: begin
                if (cls == CL_LOAD)       nxt = ST_RD;
                else if (cls == CL_STORE) nxt = ST_WR;
                else                      nxt = ST_FETCH;
            end
            ST_EXEC:  nxt = ST_RWB;
            ST_RD:    nxt = ST_LWB;
            default:  nxt = ST_FETCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_FETCH;
        else     state <= nxt;
    end
endmodule

// File: rtl/mcc_outdec.sv
module mcc_outdec
    import mcc_pkg::*;
(
    input  state_e state,
    output ctrl_t  ctl
);
    always_comb begin
        ctl = ctrl_idle();
        unique case (state)
            ST_FETCH: begin
                ctl.mem_rd    = 1'b1;
                ctl.ir_we     = 1'b1;
                ctl.pc_write  = 1'b1;
                ctl.alu_b_sel = BSRC_FOUR;
            end
            ST_DECODE: begin
                ctl.ab_we     = 1'b1;
                ctl.aluout_we = 1'b1;
                ctl.alu_b_sel = BSRC_BOFF;
            end
            ST_ADDR: begin
                ctl.alu_a_sel = 1'b1;
                ctl.alu_b_sel = BSRC_IMM;
                ctl.aluout_we = 1'b1;
            end
            ST_EXEC: begin
                ctl.alu_a_sel = 1'b1;
                ctl.alu_op    = AOP_FUNCT;
                ctl.aluout_we = 1'b1;
            end
            ST_BRANCH: begin
                ctl.alu_a_sel = 1'b1;
                ctl.alu_op    = AOP_SUB;
                ctl.pc_src    = 1'b1;
                ctl.pc_cond   = 1'b1;
            end
            ST_RD: begin
                ctl.mem_rd   = 1'b1;
                ctl.addr_sel = 1'b1;
                ctl.mdr_we   = 1'b1;
            end
            ST_WR: begin
                ctl.mem_wr   = 1'b1;
                ctl.addr_sel = 1'b1;
            end
            ST_RWB: begin
                ctl.rf_we      = 1'b1;
                ctl.rf_dst_sel = 1'b1;
            end
            ST_LWB: begin
                ctl.rf_we       = 1'b1;
                ctl.rf_data_sel = 1'b1;
            end
            default: ctl = ctrl_idle();
        endcase
    end
endmodule

// File: rtl/mcc_ctrl.sv
module mcc_ctrl
    import mcc_pkg::*;
#(
    parameter int OPW = OPC_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [OPW-1:0] opcode,
    input  logic           alu_zero,
    output logic           pc_we,
    output logic           ir_we,
    output logic           ab_we,
    output logic           aluout_we,
    output logic           mdr_we,
    output logic           mem_rd,
    output logic           mem_wr,
    output logic           rf_we,
    output logic           addr_sel,
    output logic           alu_a_sel,
    output logic [1:0]     alu_b_sel,
    output logic [1:0]     alu_op,
    output logic           pc_src,
    output logic           rf_dst_sel,
    output logic           rf_data_sel
);
    iclass_e cls;
    state_e  state;
    ctrl_t   ctl;

    mcc_decode #(.W(OPW)) u_dec (
        .opcode (opcode),
        .cls    (cls)
    );

    mcc_seq u_seq (
        .clk   (clk),
        .rst   (rst),
        .cls   (cls),
        .state (state)
    );

    mcc_outdec u_out (
        .state (state),
        .ctl   (ctl)
    );

    assign pc_we       = ctl.pc_write | (ctl.pc_cond & alu_zero);
    assign ir_we       = ctl.ir_we;
    assign ab_we       = ctl.ab_we;
    assign aluout_we   = ctl.aluout_we;
    assign mdr_we      = ctl.mdr_we;
    assign mem_rd      = ctl.mem_rd;
    assign mem_wr      = ctl.mem_wr;
    assign rf_we       = ctl.rf_we;
    assign addr_sel    = ctl.addr_sel;
    assign alu_a_sel   = ctl.alu_a_sel;
    assign alu_b_sel   = ctl.alu_b_sel;
    assign alu_op      = ctl.alu_op;
    assign pc_src      = ctl.pc_src;
    assign rf_dst_sel  = ctl.rf_dst_sel;
    assign rf_data_sel = ctl.rf_data_sel;
endmodule

// File: rtl/mcc_ctrl_chk.sv
module mcc_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       alu_zero,
    input logic       pc_we,
    input logic       ir_we,
    input logic       ab_we,
    input logic       aluout_we,
    input logic       mdr_we,
    input logic       mem_rd,
    input logic       mem_wr,
    input logic       rf_we,
    input logic       addr_sel,
    input logic       pc_src,
    input logic       rf_data_sel
);
    logic seen_rst;
    always_ff @(posedge clk) begin
        if (rst) seen_rst <= 1'b1;
        else if (seen_rst !== 1'b1) seen_rst <= 1'b0;
    end

    // R1: the first cycle after reset is a fetch
    assert_fetch_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
        (seen_rst === 1'b1 && $past(rst)) |-> (ir_we && pc_we && mem_rd));

    // R3: fetch is always followed by the operand and target loads
    assert_decode_after_fetch_R3: assert property (@(posedge clk) disable iff (rst || seen_rst !== 1'b1)
        ir_we |=> (ab_we && aluout_we && !ir_we));

    // R4: conditional PC load tracks the equality flag
    assert_branch_follows_flag_R4: assert property (@(posedge clk) disable iff (rst || seen_rst !== 1'b1)
        pc_src |-> (pc_we == alu_zero));

    // R6: a store ends the instruction
    assert_store_then_fetch_R6: assert property (@(posedge clk) disable iff (rst || seen_rst !== 1'b1)
        mem_wr |=> ir_we);

    // R7: a memory read into MDR is followed by the MDR write-back
    assert_load_writeback_R7: assert property (@(posedge clk) disable iff (rst || seen_rst !== 1'b1)
        (mdr_we && addr_sel) |=> (rf_we && rf_data_sel));

    // R9: memory strobes and register write do not collide
    assert_no_strobe_clash_R9: assert property (@(posedge clk) disable iff (rst || seen_rst !== 1'b1)
        !(mem_rd && mem_wr) && !(mem_wr && rf_we));

    // R10: any register-file write ends the instruction
    assert_wb_then_fetch_R10: assert property (@(posedge clk) disable iff (rst || seen_rst !== 1'b1)
        rf_we |=> ir_we);
endmodule

bind mcc_ctrl mcc_ctrl_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .alu_zero    (alu_zero),
    .pc_we       (pc_we),
    .ir_we       (ir_we),
    .ab_we       (ab_we),
    .aluout_we   (aluout_we),
    .mdr_we      (mdr_we),
    .mem_rd      (mem_rd),
    .mem_wr      (mem_wr),
    .rf_we       (rf_we),
    .addr_sel    (addr_sel),
    .pc_src      (pc_src),
    .rf_data_sel (rf_data_sel)
);

// File: tb/test_mcc_ctrl.sv
`timescale 1ns/1ps
module test_mcc_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] opcode = 6'h00;
    logic       alu_zero = 1'b0;
    logic pc_we, ir_we, ab_we, aluout_we, mdr_we, mem_rd, mem_wr, rf_we;
    logic addr_sel, alu_a_sel, pc_src, rf_dst_sel, rf_data_sel;
    logic [1:0] alu_b_sel, alu_op;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    mcc_ctrl i_mcc_ctrl (
        .clk(clk), .rst(rst), .opcode(opcode), .alu_zero(alu_zero),
        .pc_we(pc_we), .ir_we(ir_we), .ab_we(ab_we), .aluout_we(aluout_we),
        .mdr_we(mdr_we), .mem_rd(mem_rd), .mem_wr(mem_wr), .rf_we(rf_we),
        .addr_sel(addr_sel), .alu_a_sel(alu_a_sel), .alu_b_sel(alu_b_sel),
        .alu_op(alu_op), .pc_src(pc_src), .rf_dst_sel(rf_dst_sel),
        .rf_data_sel(rf_data_sel)
    );

    wire [16:0] got = {pc_we, ir_we, ab_we, aluout_we, mdr_we, mem_rd, mem_wr, rf_we,
                       addr_sel, alu_a_sel, alu_b_sel, alu_op, pc_src, rf_dst_sel, rf_data_sel};

    // step codes: 0 fetch, 1 decode, 2 address, 3 execute, 4 compare,
    // 5 read, 6 store, 7 reg write-back, 8 load write-back
    function automatic logic [16:0] expw(int s, logic z);
        logic pw, iw, abw, aow, mw, mr, mwr, rw, as, aa, ps, ds, dd;
        logic [1:0] bs, op;
        {pw, iw, abw, aow, mw, mr, mwr, rw, as, aa, ps, ds, dd} = '0;
        bs = 2'd0; op = 2'd0;
        case (s)
            0: begin pw = 1; iw = 1; mr = 1; bs = 2'd1; end
            1: begin abw = 1; aow = 1; bs = 2'd3; end
            2: begin aa = 1; bs = 2'd2; aow = 1; end
            3: begin aa = 1; op = 2'd2; aow = 1; end
            4: begin aa = 1; op = 2'd1; ps = 1; pw = z; end
            5: begin mr = 1; as = 1; mw = 1; end
            6: begin mwr = 1; as = 1; end
            7: begin rw = 1; ds = 1; end
            default: begin rw = 1; dd = 1; end
        endcase
        return {pw, iw, abw, aow, mw, mr, mwr, rw, as, aa, bs, op, ps, ds, dd};
    endfunction

    function automatic string tag_of(int s);
        case (s)
            0: return "R2";
            1: return "R3";
            2: return "R6/R7";
            3, 7: return "R5";
            4: return "R4";
            5, 8: return "R7";
            default: return "R6";
        endcase
    endfunction

    task automatic check(logic [16:0] exp, string tag);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: control word got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic check_r9();
        n_chk++;
        if ((mem_rd && mem_wr) || (mem_wr && rf_we)) begin
            n_bad++;
            $display("FAIL R9: rd=%0b wr=%0b rf=%0b expected no clash", mem_rd, mem_wr, rf_we);
        end
    endtask

    // {opcode, zero, step count, steps s4..s0}
    localparam int NV = 10;
    localparam logic [29:0] VEC [NV] = '{
        {6'h00, 1'b0, 3'd4, 20'h07310},
        {6'h23, 1'b0, 3'd5, 20'h85210},
        {6'h2B, 1'b0, 3'd4, 20'h06210},
        {6'h04, 1'b1, 3'd3, 20'h00410},
        {6'h04, 1'b0, 3'd3, 20'h00410},
        {6'h3F, 1'b0, 3'd2, 20'h00010},
        {6'h02, 1'b1, 3'd2, 20'h00010},
        {6'h00, 1'b1, 3'd4, 20'h07310},
        {6'h23, 1'b1, 3'd5, 20'h85210},
        {6'h2B, 1'b1, 3'd4, 20'h06210}
    };

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: run hung, got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic prev_unknown;
        prev_unknown = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        check(expw(0, 1'b0), "R1");   // reset leaves fetch

        for (int v = 0; v < NV; v++) begin
            opcode   = VEC[v][29:24];
            alu_zero = VEC[v][23];
            for (int k = 0; k < int'(VEC[v][22:20]); k++) begin
                int s;
                s = int'(VEC[v][4*k +: 4]);
                if (k > 0) begin @(negedge clk); #1; end
                if (k == 0 && prev_unknown) check(expw(s, alu_zero), "R8");
                else if (k == 0 && v > 0)   check(expw(s, alu_zero), "R10");
                else                        check(expw(s, alu_zero), tag_of(s));
                check_r9();
            end
            prev_unknown = (VEC[v][22:20] == 3'd2);
            @(negedge clk); #1;
        end
        check(expw(0, 1'b0), "R10");

        // R1: synchronous reset in the middle of a load
        opcode = 6'h23; alu_zero = 1'b0;
        @(negedge clk); #1;
        check(expw(1, 1'b0), "R3");
        @(negedge clk); #1;
        check(expw(2, 1'b0), "R7");
        rst = 1'b1;
        @(negedge clk); #1;
        rst = 1'b0;
        check(expw(0, 1'b0), "R1");
        @(negedge clk); #1;
        check(expw(1, 1'b0), "R3");

        // R4: flag flips within the compare cycle
        opcode = 6'h04;
        @(negedge clk); #1;
        alu_zero = 1'b0; #0.2;
        check(expw(4, 1'b0), "R4");
        alu_zero = 1'b1; #0.2;
        check(expw(4, 1'b1), "R4");
        @(negedge clk); #1;
        check(expw(0, 1'b1), "R10");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule